// File: doc/BRIEF.md
# Dual-Output Peripheral Interrupt Aggregator

The block gathers 32 level-sensitive peripheral interrupt lines into a 32-bit pending word. A 32-bit enable mask filters that word, and the block raises two upstream interrupt requests. The upper half of the masked word (bits 31..16) drives the peripheral request. The lower half (bits 15..0) drives the miscellaneous request. Software reaches the block through a 64-bit register port with byte enables. The pending word and the mask each sit in an 8-byte register, with the 32-bit value placed most-significant byte first in the high four byte lanes.

The same port also carries two small registers. One is a fixed ring-base value. The other is a one-byte LED and control field whose colour bits are active-low. The block drives two LED outputs directly from that field.

Byte lane k of the data buses is bits [8k+7:8k]. The register is chosen by address bits [ADDR_W-1:3], and address bits [2:0] are ignored. Offset 0x00 is the ring base, 0x08 is control, 0x10 is pending status and 0x18 is the mask. Every other offset is unmapped.

Top module: `periph_irq_concentrator`

## Requirements
- R1: The pending word captures `irq_in` on every clock edge, so bit i equals `irq_in[i]` one cycle later. A read at 0x10 returns it with bits 31..24 in lane 4, bits 23..16 in lane 5, bits 15..8 in lane 6 and bits 7..0 in lane 7, and zeros in lanes 0..3.
- R2: The mask at 0x18 uses the same lane layout as R1. Each of lanes 4..7 is written only when its byte enable is set. Lanes 0..3 always read zero, and the mask changes only on a write.
- R3: `irq_periph` is high exactly when the pending word AND the mask is nonzero in bits 31..16. It is registered one cycle after the pending word and the mask.
- R4: `irq_misc` is high exactly when the pending word AND the mask is nonzero in bits 15..0, with the same one-cycle timing as R3.
- R5: A write to 0x10 has no effect on the pending word or on either interrupt output.
- R6: The ring-base register reads 0x10 in lane 7 and zeros elsewhere. Writes to it are ignored.
- R7: The control byte sits in lane 7 of 0x08. Bit 4 turns red off and bit 5 turns green off. Bit 0, the password-clear flag, always reads as 1. The other bits store what was written.
- R8: `led_red_on` is the inverse of control bit 4 and `led_green_on` is the inverse of control bit 5. Both take their new value at the clock edge that completes the control write. Writing 0x00 lights both colours (white/orange), 0x10 gives green only, 0x20 gives red only and 0x30 turns the LED off.
- R9: Each read is answered by `rd_valid` and `rd_data` one cycle after the request. Lanes whose byte enable was clear read zero, and unmapped offsets read zero in every lane.
- R10: After reset the mask is zero, the control byte is 0x30 (reading back as 0x31), and both interrupt outputs and both LED outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Peripheral interrupt lines, bit i is line i |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address, bits [ADDR_W-1:3] choose the register |
| req_be | input | 8 | Byte-lane enables |
| req_wdata | input | 64 | Write data, lane k in bits [8k+7:8k] |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read response data |
| irq_periph | output | 1 | Upstream request for lines 31..16 |
| irq_misc | output | 1 | Upstream request for lines 15..0 |
| led_red_on | output | 1 | Red LED drive, active high |
| led_green_on | output | 1 | Green LED drive, active high |

## Verification
The bound checker checks, on every cycle, the following:
- one-cycle capture of the lines into the pending word;
- the registered relation between pending, mask and each upstream output;
- the stability of the mask and LED outputs when nothing is written;
- the timing of read responses;
- the fixed ring-base and password-clear readback values;
- zeros from unmapped offsets.

Only the bench's scenarios can show the following:
- the big-endian lane placement of the pending word and the mask;
- partial byte-enable writes and reads;
- the four LED colour codes;
- the reset values;
- the fact that a write to the pending register leaves the outputs untouched. The bench shows this by comparing against its cycle model while such writes are issued.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LANES     = 8;
    localparam int LANE_W    = 8;
    localparam int WORD_W    = 32;
    localparam int NUM_REGS  = 4;
    localparam logic [7:0] RING_BASE_VAL = 8'h10;
    localparam logic [7:0] CTRL_RESET    = 8'h30;

    typedef enum logic [1:0] {
        SEL_RING = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] spare_hi;
        logic       green_off;
        logic       red_off;
        logic [2:0] spare_lo;
        logic       pwd_clr;
    } ctrl_t;

    // 32-bit value placed most-significant byte first in lanes 4..7
    function automatic logic [63:0] word_to_lanes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24], 32'h0};
    endfunction

    function automatic logic [63:0] expand_be(input logic [7:0] be);
        logic [63:0] m;
        for (int k = 0; k < LANES; k++) begin
            m[k*LANE_W +: LANE_W] = {LANE_W{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int GROUPS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  irq_in,
    input  logic [LINES-1:0]  mask_word,
    output logic [LINES-1:0]  status_word,
    output logic [GROUPS-1:0] grp_irq
);

    localparam int GRP_W = LINES / GROUPS;

    logic [LINES-1:0] status_q;
    logic [LINES-1:0] masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= irq_in;
        end
    end

    assign masked      = status_q & mask_word;
    assign status_word = status_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic req_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q <= 1'b0;
            end else begin
                req_q <= |masked[g*GRP_W +: GRP_W];
            end
        end
        assign grp_irq[g] = req_q;
    end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_be,
    input  logic [63:0]       req_wdata,
    input  logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] mask_word,
    output ctrl_t             ctrl,
    output logic              rd_valid,
    output logic [63:0]       rd_data
);

    localparam int IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0] idx;
    logic             mapped;
    reg_sel_e         sel;
    logic             wr_hit;
    logic             rd_req;
    logic [2:0]       unused_lo;

    assign idx       = req_addr[ADDR_W-1:3];
    assign unused_lo = req_addr[2:0];
    assign mapped    = (idx < IDX_W'(NUM_REGS));
    assign sel       = reg_sel_e'(idx[1:0]);
    assign wr_hit    = req_valid && req_write && mapped;
    assign rd_req    = req_valid && !req_write;

    // mask bytes, lanes 4..7 only
    logic [7:0] mask_byte [4];

    for (genvar l = 0; l < 4; l++) begin : g_mask
        localparam int LANE = l + 4;
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_byte[l] <= '0;
            end else if (wr_hit && sel == SEL_MASK && req_be[LANE]) begin
                mask_byte[l] <= req_wdata[LANE*LANE_W +: LANE_W];
            end
        end
    end

    // lane 4 is the most significant byte of the word
    assign mask_word = {mask_byte[0], mask_byte[1], mask_byte[2], mask_byte[3]};

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
        end else if (wr_hit && sel == SEL_CTRL && req_be[7]) begin
            ctrl_q <= ctrl_t'(req_wdata[63:56]);
        end
    end

    assign ctrl = ctrl_q;

    logic [63:0] rd_mux;
    ctrl_t       ctrl_view;

    always_comb begin
        ctrl_view         = ctrl_q;
        ctrl_view.pwd_clr = 1'b1;
        rd_mux            = '0;
        if (mapped) begin
            unique case (sel)
                SEL_RING: rd_mux = {RING_BASE_VAL, 56'h0};
                SEL_CTRL: rd_mux = {8'(ctrl_view), 56'h0};
                SEL_STAT: rd_mux = word_to_lanes(status_word);
                SEL_MASK: rd_mux = word_to_lanes(mask_word);
                default:  rd_mux = '0;
            endcase
        end
    end

    logic        rd_valid_q;
    logic [63:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_req;
            rd_data_q  <= rd_req ? (rd_mux & expand_be(req_be)) : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

endmodule

// File: rtl/periph_irq_concentrator.sv
module periph_irq_concentrator
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       irq_in,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_be,
    input  logic [63:0]       req_wdata,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              irq_periph,
    output logic              irq_misc,
    output logic              led_red_on,
    output logic              led_green_on
);

    localparam int GROUPS = 2;

    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] mask_w;
    logic [GROUPS-1:0] grp_irq;
    ctrl_t             ctrl;

    irqc_status #(
        .LINES (WORD_W),
        .GROUPS(GROUPS)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .mask_word  (mask_w),
        .status_word(status_w),
        .grp_irq    (grp_irq)
    );

    irqc_regfile #(
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .status_word(status_w),
        .mask_word  (mask_w),
        .ctrl       (ctrl),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign irq_periph   = grp_irq[GROUPS-1];
    assign irq_misc     = grp_irq[0];
    assign led_red_on   = !ctrl.red_off;
    assign led_green_on = !ctrl.green_off;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       irq_in,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [7:0]        req_be,
    input logic [31:0]       status_w,
    input logic [31:0]       mask_w,
    input logic              rd_valid,
    input logic [63:0]       rd_data,
    input logic              irq_periph,
    input logic              irq_misc,
    input logic              led_red_on,
    input logic              led_green_on
);

    logic [ADDR_W-4:0] idx;
    logic              any_wr;
    assign idx    = req_addr[ADDR_W-1:3];
    assign any_wr = req_valid && req_write;

    AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> status_w == $past(irq_in)); // R1

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !any_wr |=> $stable(mask_w)); // R2

    AST_PERIPH_OUT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_periph == $past(|(status_w[31:16] & mask_w[31:16]))); // R3

    AST_MISC_OUT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_misc == $past(|(status_w[15:0] & mask_w[15:0]))); // R4

    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (any_wr && idx == 2) |=> status_w == $past(irq_in)); // R5

    AST_RING_VALUE: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(idx == 0 && req_be[7])) |-> rd_data[63:56] == 8'h10); // R6

    AST_PWD_SET: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(idx == 1 && req_be[7])) |-> rd_data[56]); // R7

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !any_wr |=> $stable({led_red_on, led_green_on})); // R8

    AST_RD_TIMING: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rd_valid == $past(req_valid && !req_write)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(idx >= 4)) |-> rd_data == 64'h0); // R9

endmodule

bind periph_irq_concentrator irqc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_in      (irq_in),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .status_w    (status_w),
    .mask_w      (mask_w),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .irq_periph  (irq_periph),
    .irq_misc    (irq_misc),
    .led_red_on  (led_red_on),
    .led_green_on(led_green_on)
);

// File: tb/tb_periph_irq_concentrator.sv
`timescale 1ns/1ps
module tb_periph_irq_concentrator;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   irq_in = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_be = '0;
    logic [63:0]   req_wdata = '0;
    logic          rd_valid, irq_periph, irq_misc, led_red_on, led_green_on;
    logic [63:0]   rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    periph_irq_concentrator #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_periph(irq_periph), .irq_misc(irq_misc),
        .led_red_on(led_red_on), .led_green_on(led_green_on)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_st, m_mk;
    logic [7:0]  m_ctrl;
    logic        m_per, m_mis, m_rv;
    logic [63:0] m_rd;
    int          m_ridx;

    function automatic logic [63:0] pack_be(input logic [31:0] w);
        logic [63:0] r = '0;
        for (int k = 4; k < 8; k++) r[8*k +: 8] = w[8*(7-k) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] lane_mask(input logic [7:0] be);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) if (be[k]) r[8*k +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic logic [63:0] model_read(input int ix);
        case (ix)
            0:       return {8'h10, 56'h0};
            1:       return {(m_ctrl | 8'h01), 56'h0};
            2:       return pack_be(m_st);
            3:       return pack_be(m_mk);
            default: return 64'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = '0; m_mk = '0; m_ctrl = 8'h30;
            m_per = 0; m_mis = 0; m_rv = 0; m_rd = '0; m_ridx = 0;
        end else begin
            m_per = ((m_st & m_mk) >> 16) != 0;
            m_mis = ((m_st & m_mk) & 32'h0000FFFF) != 0;
            m_rv  = req_valid && !req_write;
            if (m_rv) begin
                m_ridx = int'(req_addr >> 3);
                m_rd   = model_read(m_ridx) & lane_mask(req_be);
            end else begin
                m_rd = '0;
            end
            if (req_valid && req_write) begin
                if (int'(req_addr >> 3) == 3) begin
                    for (int k = 4; k < 8; k++)
                        if (req_be[k]) m_mk[8*(7-k) +: 8] = req_wdata[8*k +: 8];
                end
                if (int'(req_addr >> 3) == 1 && req_be[7]) m_ctrl = req_wdata[63:56];
            end
            m_st = irq_in;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 irq_periph", 64'(irq_periph), 64'(m_per));
            chk("R4 irq_misc", 64'(irq_misc), 64'(m_mis));
            chk("R8 led_red_on", 64'(led_red_on), 64'(!m_ctrl[4]));
            chk("R8 led_green_on", 64'(led_green_on), 64'(!m_ctrl[5]));
            chk("R9 rd_valid", 64'(rd_valid), 64'(m_rv));
            if (m_rv) begin
                case (m_ridx)
                    0:       chk("R6 ring read", rd_data, m_rd);
                    1:       chk("R7 ctrl read", rd_data, m_rd);
                    2:       chk("R1 status read", rd_data, m_rd);
                    3:       chk("R2 mask read", rd_data, m_rd);
                    default: chk("R9 unmapped read", rd_data, m_rd);
                endcase
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int a, input logic [7:0] be, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input int a, input logic [7:0] be);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = AW'(a); req_be = be;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic lines(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk("R10 irq_periph", 64'(irq_periph), 64'h0);
        chk("R10 irq_misc", 64'(irq_misc), 64'h0);
        chk("R10 leds", 64'({led_red_on, led_green_on}), 64'h0);
        rd(8'h18, 8'hFF);
        rd(8'h08, 8'hFF);
        @(negedge clk);
        // R6 ring base fixed
        rd(8'h00, 8'hFF);
        wr(8'h00, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h00, 8'hFF);
        // R1 status layout, mask zero so no outputs
        lines(32'h1234_5678);
        rd(8'h10, 8'hFF);
        // R2 full mask then partial lane writes
        wr(8'h18, 8'hF0, pack_be(32'hFFFF_FFFF));
        rd(8'h18, 8'hFF);
        wr(8'h18, 8'h40, 64'h0);   // clears bits 15..8
        rd(8'h18, 8'hFF);
        wr(8'h18, 8'h0F, 64'hFFFF_FFFF); // low lanes ignored
        rd(8'h18, 8'hFF);
        // R3 / R4 patterns
        lines(32'h8000_0000);
        lines(32'h0001_0000);
        lines(32'h0000_8000);  // masked off in bits 15..8
        lines(32'h0000_0001);
        lines(32'h8001_0100);
        wr(8'h18, 8'hF0, pack_be(32'h0000_FFFF));
        repeat (2) @(negedge clk);
        wr(8'h18, 8'hF0, pack_be(32'hFFFF_0000));
        repeat (2) @(negedge clk);
        // R5 status writes ignored
        lines(32'h0000_0000);
        wr(8'h10, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
        repeat (2) @(negedge clk);
        rd(8'h10, 8'hFF);
        // R7 / R8 LED codes
        wr(8'h08, 8'h80, {8'h00, 56'h0});
        rd(8'h08, 8'hFF);
        wr(8'h08, 8'h80, {8'h10, 56'h0});
        wr(8'h08, 8'h80, {8'h20, 56'h0});
        wr(8'h08, 8'h80, {8'hF6, 56'h0});
        rd(8'h08, 8'hFF);
        wr(8'h08, 8'h7F, {8'h00, 56'h0}); // lane 7 not enabled
        wr(8'h08, 8'h80, {8'h30, 56'h0});
        rd(8'h08, 8'hFF);
        // R9 unmapped and partial enables
        rd(8'h20, 8'hFF);
        rd(8'hF8, 8'hFF);
        wr(8'h28, 8'hFF, 64'hDEAD_BEEF_0000_0001);
        lines(32'hA5C3_0F81);
        rd(8'h10, 8'h80);
        rd(8'h14, 8'h30);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule